// File: doc/BRIEF.md
# Fixed-Slot Prioritized Interrupt Controller

This block sits in front of a processor core and chooses which interrupt the core sees. There are sixteen priority levels, numbered 0 to 15, and a smaller number always wins. The slots are fixed:

| Level | Use |
|-------|-----|
| 0 | reset request |
| 1 | non-maskable request |
| 2, 3 | reserved, never asserted |
| 4 to 15 | one external maskable request line each |

Each external line and the non-maskable line is caught on its rising edge into a pending flag. A pending flag is cleared when the core acknowledges that level, or when software writes a clear. The output is a level number and a valid flag. A combinational priority encoder drives them from the requests that qualify in the current cycle.

A two-bit register port gives software four views:

- an enable word: a global enable plus one enable bit per external level;
- the pending flags, which can only be read;
- a write-one-to-set word;
- a write-one-to-clear word.

The reset and non-maskable levels do not look at the enable word at all. A maskable level may become pending while it is disabled. It is presented once it is enabled.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After rst_n is released, all pending flags and the enable word are zero. With no reset request, irq_valid_o is 0.
- R2: While rst_req_i is 1, the block presents level 0 with irq_valid_o = 1, whatever the pending flags and enables are.
- R3: A rising edge on nmi_i sets pending bit 1. Level 1 is then presented, ignoring the enable word, above every external level and below only the reset request.
- R4: Levels 2 and 3 never become pending. They read as 0 in both the pending and enable views, and irq_level_o never shows 2 or 3 while irq_valid_o is 1.
- R5: A rising edge on bit k of ext_irq_i sets pending bit k+4 at that clock edge. A line held high does not set the bit again after it has been cleared.
- R6: irq_level_o is the lowest-numbered qualifying level. irq_valid_o is 0 when no level qualifies.
- R7: An external level L qualifies only when all three hold:
  - its pending bit L is set;
  - enable bit L is set;
  - the global enable (enable bit 0) is set.
  While it does not qualify, it can still become pending.
- R8: ack_i = 1 with ack_level_i = L clears pending bit L at that edge. An acknowledge of level 0 has no effect.
- R9: The register address selects the view:

  | Address | View | Behaviour |
  |---------|------|-----------|
  | 0 | enable | read/write; bit 0 is the global enable, bits 4..15 are the per-level enables |
  | 1 | pending | read only; writes are ignored; bit 0 shows rst_req_i live |
  | 2 | set | write-one-to-set for bits 4..15; reads as 0 |
  | 3 | clear | write-one-to-clear for bits 1 and 4..15; reads as 0 |

  Reads are combinational.
- R10: When a set (an edge or a set write) and a clear (an acknowledge or a clear write) hit the same pending bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| rst_req_i | input | 1 | reset request, level 0, level-sensitive |
| nmi_i | input | 1 | non-maskable request, level 1, edge-captured |
| ext_irq_i | input | 12 | external requests; bit k maps to level k+4 |
| ack_i | input | 1 | acknowledge strobe from the core |
| ack_level_i | input | 4 | level being acknowledged |
| reg_we_i | input | 1 | register write strobe |
| reg_addr_i | input | 2 | register view select |
| reg_wdata_i | input | 16 | register write data |
| reg_rdata_o | output | 16 | register read data (combinational) |
| irq_valid_o | output | 1 | a level is being presented |
| irq_level_o | output | 4 | presented level number |

## Verification
The bench sweeps all 4096 combinations of external pending flags with every enable on. An encoder with a reversed or off-by-one priority chain would then present the wrong level. It then sweeps all 4096 enable masks over a full pending word; a broken mask or global-enable gate would let a disabled level through. Directed cycles collide a set with an acknowledge, and an edge with a clear write, so that a design where clear wins would lose an interrupt. Further cases target the reserved levels, ignored writes to the pending view, an acknowledge of level 0, and a line held high after its flag has been cleared; a design that re-latched that line would fire the interrupt again.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int unsigned NUM_LEVELS = 16;
  localparam int unsigned LVL_W      = $clog2(NUM_LEVELS);
  localparam int unsigned EXT_BASE   = 4;
  localparam int unsigned NUM_EXT    = NUM_LEVELS - EXT_BASE;
  localparam int unsigned NMI_LEVEL  = 1;
  localparam int unsigned GIE_BIT    = 0;
  localparam int unsigned ADDR_W     = 2;

  typedef enum logic [ADDR_W-1:0] {
    VIEW_ENABLE  = 2'd0,
    VIEW_PENDING = 2'd1,
    VIEW_SET     = 2'd2,
    VIEW_CLEAR   = 2'd3
  } reg_view_e;

  // bits lo..hi set
  function automatic logic [NUM_LEVELS-1:0] span_mask(input int unsigned lo, input int unsigned hi);
    logic [NUM_LEVELS-1:0] m;
    m = '0;
    for (int unsigned i = 0; i < NUM_LEVELS; i++)
      if (i >= lo && i <= hi) m[i] = 1'b1;
    return m;
  endfunction

  localparam logic [NUM_LEVELS-1:0] EXT_MASK   = span_mask(EXT_BASE, NUM_LEVELS-1);
  localparam logic [NUM_LEVELS-1:0] EN_MASK    = EXT_MASK | span_mask(GIE_BIT, GIE_BIT);
  localparam logic [NUM_LEVELS-1:0] CLR_MASK   = EXT_MASK | span_mask(NMI_LEVEL, NMI_LEVEL);

  // index of lowest set bit (0 when none)
  function automatic logic [LVL_W-1:0] lowest_set(input logic [NUM_LEVELS-1:0] v);
    logic [LVL_W-1:0] r;
    r = '0;
    for (int i = NUM_LEVELS-1; i >= 0; i--)
      if (v[i]) r = LVL_W'(i);
    return r;
  endfunction

  // one-hot decode of a level number
  function automatic logic [NUM_LEVELS-1:0] level_onehot(input logic [LVL_W-1:0] l);
    logic [NUM_LEVELS-1:0] r;
    r = '0;
    r[l] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/irq_pend_cell.sv
module irq_pend_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o,
  output logic set_evt_o
);
  logic req_q;

  // set beats clear when both arrive in one cycle
  assign set_evt_o = (req_i & ~req_q) | set_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      pend_o <= 1'b0;
    end else begin
      req_q <= req_i;
      if (set_evt_o)  pend_o <= 1'b1;
      else if (clr_i) pend_o <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import prio_irq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [NUM_LEVELS-1:0] wdata_i,
  input  logic [NUM_LEVELS-1:0] pend_view_i,
  output logic [NUM_LEVELS-1:0] en_o,
  output logic [NUM_LEVELS-1:0] set_o,
  output logic [NUM_LEVELS-1:0] clr_o,
  output logic [NUM_LEVELS-1:0] rdata_o
);
  logic [NUM_LEVELS-1:0] en_q;
  reg_view_e view;

  assign view  = reg_view_e'(addr_i);
  assign en_o  = en_q;
  assign set_o = (we_i && view == VIEW_SET)   ? (wdata_i & EXT_MASK) : '0;
  assign clr_o = (we_i && view == VIEW_CLEAR) ? (wdata_i & CLR_MASK) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             en_q <= '0;
    else if (we_i && view == VIEW_ENABLE)   en_q <= wdata_i & EN_MASK;
  end

  always_comb begin
    case (view)
      VIEW_ENABLE:  rdata_o = en_q;
      VIEW_PENDING: rdata_o = pend_view_i;
      default:      rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
  import prio_irq_pkg::*;
(
  input  logic [NUM_LEVELS-1:0] qual_i,
  output logic                  valid_o,
  output logic [LVL_W-1:0]      level_o
);
  assign valid_o = |qual_i;
  assign level_o = lowest_set(qual_i);
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rst_req_i,
  input  logic                  nmi_i,
  input  logic [NUM_EXT-1:0]    ext_irq_i,
  input  logic                  ack_i,
  input  logic [LVL_W-1:0]      ack_level_i,
  input  logic                  reg_we_i,
  input  logic [ADDR_W-1:0]     reg_addr_i,
  input  logic [NUM_LEVELS-1:0] reg_wdata_i,
  output logic [NUM_LEVELS-1:0] reg_rdata_o,
  output logic                  irq_valid_o,
  output logic [LVL_W-1:0]      irq_level_o
);
  logic [NUM_LEVELS-1:0] pend;
  logic [NUM_LEVELS-1:0] set_evt;
  logic [NUM_LEVELS-1:0] en;
  logic [NUM_LEVELS-1:0] set_wr;
  logic [NUM_LEVELS-1:0] clr_wr;
  logic [NUM_LEVELS-1:0] ack_hit;
  logic [NUM_LEVELS-1:0] qual;
  logic [NUM_LEVELS-1:0] pend_view;
  logic                  gie;

  assign gie     = en[GIE_BIT];
  assign ack_hit = ack_i ? level_onehot(ack_level_i) : '0;

  irq_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .pend_view_i(pend_view),
    .en_o       (en),
    .set_o      (set_wr),
    .clr_o      (clr_wr),
    .rdata_o    (reg_rdata_o)
  );

  for (genvar l = 0; l < NUM_LEVELS; l++) begin : g_lvl
    if (l == NMI_LEVEL) begin : g_nmi
      irq_pend_cell u_cell (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_i    (nmi_i),
        .set_i    (1'b0),
        .clr_i    (clr_wr[l] | ack_hit[l]),
        .pend_o   (pend[l]),
        .set_evt_o(set_evt[l])
      );
      assign qual[l]      = pend[l];
      assign pend_view[l] = pend[l];
    end else if (l >= EXT_BASE) begin : g_ext
      irq_pend_cell u_cell (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_i    (ext_irq_i[l-EXT_BASE]),
        .set_i    (set_wr[l]),
        .clr_i    (clr_wr[l] | ack_hit[l]),
        .pend_o   (pend[l]),
        .set_evt_o(set_evt[l])
      );
      assign qual[l]      = pend[l] & en[l] & gie;
      assign pend_view[l] = pend[l];
    end else if (l == 0) begin : g_rst
      assign pend[l]      = 1'b0;
      assign set_evt[l]   = 1'b0;
      assign qual[l]      = rst_req_i;
      assign pend_view[l] = rst_req_i;
    end else begin : g_rsvd
      assign pend[l]      = 1'b0;
      assign set_evt[l]   = 1'b0;
      assign qual[l]      = 1'b0;
      assign pend_view[l] = 1'b0;
    end
  end

  irq_prio_enc u_enc (
    .qual_i (qual),
    .valid_o(irq_valid_o),
    .level_o(irq_level_o)
  );
endmodule

// File: rtl/prio_irq_checker.sv
module prio_irq_checker
  import prio_irq_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic                  rst_req_i,
  input logic                  nmi_i,
  input logic                  ack_i,
  input logic [LVL_W-1:0]      ack_level_i,
  input logic                  gie,
  input logic [NUM_LEVELS-1:0] qual,
  input logic [NUM_LEVELS-1:0] pend,
  input logic [NUM_LEVELS-1:0] set_evt,
  input logic                  irq_valid_o,
  input logic [LVL_W-1:0]      irq_level_o
);
  a_r2_reset_first: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_i |-> (irq_valid_o && irq_level_o == '0));

  a_r3_nmi_shown: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nmi_i) |=> (irq_valid_o && irq_level_o <= LVL_W'(NMI_LEVEL)));

  a_r4_no_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid_o |-> (irq_level_o != LVL_W'(2) && irq_level_o != LVL_W'(3)));

  a_r6_none_higher: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid_o |-> (qual[irq_level_o] &&
      ((qual & ((NUM_LEVELS'(1) << irq_level_o) - NUM_LEVELS'(1))) == '0)));

  a_r6_idle_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (qual == '0) |-> !irq_valid_o);

  a_r7_gie_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |-> !(irq_valid_o && irq_level_o >= LVL_W'(EXT_BASE)));

  a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && ack_level_i != '0 && !set_evt[ack_level_i]) |=> !pend[$past(ack_level_i)]);

  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set_evt != '0) |=> ((pend & $past(set_evt)) == $past(set_evt)));
endmodule

bind prio_irq_ctrl prio_irq_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rst_req_i  (rst_req_i),
  .nmi_i      (nmi_i),
  .ack_i      (ack_i),
  .ack_level_i(ack_level_i),
  .gie        (gie),
  .qual       (qual),
  .pend       (pend),
  .set_evt    (set_evt),
  .irq_valid_o(irq_valid_o),
  .irq_level_o(irq_level_o)
);

// File: tb/tb_prio_irq_ctrl.sv
`timescale 1ns/1ps
module tb_prio_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rst_req_i = 1'b0;
  logic        nmi_i = 1'b0;
  logic [11:0] ext_irq_i = '0;
  logic        ack_i = 1'b0;
  logic [3:0]  ack_level_i = '0;
  logic        reg_we_i = 1'b0;
  logic [1:0]  reg_addr_i = '0;
  logic [15:0] reg_wdata_i = '0;
  logic [15:0] reg_rdata_o;
  logic        irq_valid_o;
  logic [3:0]  irq_level_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  prio_irq_ctrl dut (.*);

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    reg_we_i = 1'b1; reg_addr_i = 2'(a); reg_wdata_i = 16'(d);
    step();
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    reg_addr_i = 2'(a);
    #0.5;
    d = int'(reg_rdata_o);
  endtask

  // expected output code: valid<<4 | level, from pending/enable words
  function automatic int model(input int pend12, input int en12, input bit g);
    for (int i = 0; i < 12; i++)
      if (pend12[i] && en12[i] && g) return 16 | (i + 4);
    return 0;
  endfunction

  function automatic int outcode();
    return irq_valid_o ? (16 | int'(irq_level_o)) : 0;
  endfunction

  task automatic chk_out(input string req, input int exp);
    chk(outcode() == exp, req, outcode(), exp);
  endtask

  initial begin : watchdog
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    int d;
    step(); step();
    rst_n = 1'b1;
    step();

    // R1 reset state
    chk_out("R1 idle", 0);
    rd(0, d); chk(d == 0, "R1 enable", d, 0);
    rd(1, d); chk(d == 0, "R1 pending", d, 0);

    // R4 and R9 register views
    wr(2, 16'hFFFF);
    rd(1, d); chk(d == 16'hFFF0, "R4 set reserved", d, 16'hFFF0);
    wr(0, 16'hFFFF);
    rd(0, d); chk(d == 16'hFFF1, "R4 enable reserved", d, 16'hFFF1);
    rd(2, d); chk(d == 0, "R9 set reads zero", d, 0);
    rd(3, d); chk(d == 0, "R9 clear reads zero", d, 0);
    wr(1, 0);
    rd(1, d); chk(d == 16'hFFF0, "R9 pending write ignored", d, 16'hFFF0);
    chk_out("R6 level 4 wins", 16 | 4);
    wr(3, 16'hFFFF);
    rd(1, d); chk(d == 0, "R9 clear all", d, 0);
    chk_out("R6 empty", 0);

    // R2 reset request
    wr(0, 0);
    rst_req_i = 1'b1; #0.5;
    chk_out("R2 disabled", 16);
    rd(1, d); chk(d == 1, "R9 pending bit0 live", d, 1);
    ack_i = 1'b1; ack_level_i = 4'd0; step(); ack_i = 1'b0;
    chk_out("R8 ack0 no effect", 16);
    rst_req_i = 1'b0; #0.5;
    chk_out("R2 released", 0);

    // R3 NMI with global enable off
    nmi_i = 1'b1; step();
    chk_out("R3 nmi shown", 16 | 1);
    rd(1, d); chk(d == 2, "R3 pending bit1", d, 2);
    wr(0, 16'hFFF1);
    wr(2, 16'h0100);
    chk_out("R3 over external", 16 | 1);
    rst_req_i = 1'b1; #0.5;
    chk_out("R2 over nmi", 16);
    rst_req_i = 1'b0;
    ack_i = 1'b1; ack_level_i = 4'd1; step(); ack_i = 1'b0;
    chk_out("R8 nmi ack", 16 | 8);
    nmi_i = 1'b0; step(); nmi_i = 1'b1; step();
    chk_out("R3 second edge", 16 | 1);
    wr(3, 16'h0002);
    chk_out("R9 clear nmi", 16 | 8);
    nmi_i = 1'b0;
    wr(3, 16'hFFFF);

    // R5 edge latching on line 3 -> level 7
    ext_irq_i[3] = 1'b1; step();
    rd(1, d); chk(d == 16'h0080, "R5 edge to level 7", d, 16'h0080);
    chk_out("R5 level 7 out", 16 | 7);
    ack_i = 1'b1; ack_level_i = 4'd7; step(); ack_i = 1'b0;
    step();
    rd(1, d); chk(d == 0, "R5 held high no relatch", d, 0);
    chk_out("R8 ack 7", 0);
    ext_irq_i[3] = 1'b0; step();

    // R7 pending while masked
    wr(0, 16'hFFF0);
    ext_irq_i[11] = 1'b1; step(); ext_irq_i[11] = 1'b0;
    rd(1, d); chk(d == 16'h8000, "R7 latched gie off", d, 16'h8000);
    chk_out("R7 gie off hidden", 0);
    wr(0, 16'h0001);
    chk_out("R7 level bit off hidden", 0);
    wr(0, 16'h8001);
    chk_out("R7 enabled shown", 16 | 15);

    // R10 set write collides with ack
    wr(2, 16'h0020);
    ack_i = 1'b1; ack_level_i = 4'd5;
    reg_we_i = 1'b1; reg_addr_i = 2'd2; reg_wdata_i = 16'h0020;
    step();
    ack_i = 1'b0; reg_we_i = 1'b0;
    rd(1, d); chk(d[5] == 1'b1, "R10 set beats ack", d, 16'h8020);
    // R10 edge collides with clear write
    ext_irq_i[0] = 1'b1;
    reg_we_i = 1'b1; reg_addr_i = 2'd3; reg_wdata_i = 16'h0010;
    step();
    reg_we_i = 1'b0; ext_irq_i[0] = 1'b0;
    rd(1, d); chk(d[4] == 1'b1, "R10 edge beats clear", d, 16'h8030);
    wr(3, 16'hFFFF);

    // R6 sweep: every pending pattern, all enabled
    wr(0, 16'hFFF1);
    for (int p = 0; p < 4096; p++) begin
      wr(2, p << 4);
      chk_out("R6 pending sweep", model(p, 12'hFFF, 1'b1));
      wr(3, 16'hFFF0);
    end

    // R7 sweep: every enable mask, all pending
    wr(2, 16'hFFF0);
    for (int e = 0; e < 4096; e++) begin
      wr(0, (e << 4) | 1);
      chk_out("R7 enable sweep", model(12'hFFF, e, 1'b1));
    end
    wr(0, 16'hFFF0);
    chk_out("R7 gie off full", model(12'hFFF, 12'hFFF, 1'b0));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule